// File: doc/BRIEF.md
# Bit-Serial Processing Element Grid

This block is a two-dimensional grid of one-bit processing elements, four rows by four columns by default, wired as a torus. A controller broadcasts one micro-instruction per cycle, and every element executes it. Each element holds three one-bit registers: an accumulator, a carry and an activity flag. It also has a full adder, an operand selector and a private single-bit-wide memory. Wider arithmetic is built by the controller, which steps through the bits of the operands one cycle at a time.

The operand selector chooses one of five sources: the element's own memory bit, the accumulator, the activity flag, the carry held by one of the four torus neighbours, or a bit broadcast by the controller. With the neighbour carry as operand, a sum can ripple from element to element. The activity flag stops an element from writing its memory, while the element keeps executing the shared instruction.

A separate host path writes and reads whole bit planes: one bit per element at a common address. It is used to load operands and to collect results.

Top module: `bitplane_grid`

## Requirements
- R1: After reset every element holds accumulator 0, carry 0 and activity 1. Register planes are read out on qPlane, cPlane and aPlane, where bit r*COLS+c belongs to the element in row r, column c.
- R2: With uopValid high and uopOp=1 (add), each element forms accumulator + carry + operand. It takes the sum bit into the accumulator and the carry-out into the carry, at the next clock edge.
- R3: uopOp=2 loads the operand into the accumulator, and uopOp=3 loads the operand into the activity flag. Other registers are unchanged.
- R4: uopOp=4 clears the carry of every element, so a new multi-bit add can begin.
- R5: uopSrc picks the operand. 0 selects the memory bit at uopAddr, 1 the accumulator, 2 the activity flag, 3 the carry of the neighbour named by uopDir, and 4 the broadcast bit uopBcast. Codes 5 to 7 give operand 0.
- R6: uopDir selects the neighbour, with row and column indices taken modulo the grid size. 0 is north (row-1), 1 is east (col+1), 2 is south (row+1) and 3 is west (col-1).
- R7: uopOp=5 stores the adder's sum bit, and uopOp=6 stores the operand, into memory at uopAddr. Only elements with activity 1 write. Elements with activity 0 keep their memory bit, and no register changes on either store.
- R8: hostWe writes hostWrPlane bit r*COLS+c into element (r,c) at hostAddr, whatever its activity flag. hostRdPlane shows, without a clock, the memory plane at hostAddr.
- R9: In a cycle where hostWe is high, micro-op stores are dropped in every element and the host write takes place. Register updates of a non-store micro-op still happen in that cycle.
- R10: With uopValid low, or with uopOp 0 or 7, no register and no memory bit changes through the micro-op path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| uopValid | input | 1 | Micro-instruction present this cycle |
| uopOp | input | 3 | Action code (R2, R3, R4, R7, R10) |
| uopSrc | input | 3 | Operand source code (R5) |
| uopDir | input | 2 | Neighbour direction (R6) |
| uopAddr | input | AW | Memory bit address for operand and store |
| uopBcast | input | 1 | Bit broadcast to all elements |
| hostWe | input | 1 | Host plane write enable |
| hostAddr | input | AW | Host plane address for write and read |
| hostWrPlane | input | ROWS*COLS | Plane data written by the host |
| hostRdPlane | output | ROWS*COLS | Memory plane at hostAddr |
| qPlane | output | ROWS*COLS | Accumulator plane |
| cPlane | output | ROWS*COLS | Carry plane |
| aPlane | output | ROWS*COLS | Activity plane |

## Verification
A host plane write and a micro-instruction can fall in the same cycle. The bench provokes this in three ways: a store to a different address, a store to the same address, and an accumulator load. It judges the result by reading both address planes back and comparing the register planes against a bench-side model. The store must leave its target plane untouched. The host data must land, and the accumulator load must still take effect.

// File: rtl/bspe_pkg.sv
package bspe_pkg;
  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_ADD   = 3'd1;
  localparam logic [2:0] OP_LDQ   = 3'd2;
  localparam logic [2:0] OP_LDA   = 3'd3;
  localparam logic [2:0] OP_CLRC  = 3'd4;
  localparam logic [2:0] OP_STSUM = 3'd5;
  localparam logic [2:0] OP_STMUX = 3'd6;

  localparam logic [2:0] SRC_MEM = 3'd0;
  localparam logic [2:0] SRC_Q   = 3'd1;
  localparam logic [2:0] SRC_A   = 3'd2;
  localparam logic [2:0] SRC_NBR = 3'd3;
  localparam logic [2:0] SRC_BC  = 3'd4;

  typedef struct packed {
    logic       doAdd;
    logic       ldQ;
    logic       ldA;
    logic       clrC;
    logic       memWe;
    logic       storeSum;
    logic [2:0] src;
    logic [1:0] dir;
  } strobesT;
endpackage

// File: rtl/bspe_ctrl.sv
module bspe_ctrl
  import bspe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       uopValid,
  input  logic [2:0] uopOp,
  input  logic [2:0] uopSrc,
  input  logic [1:0] uopDir,
  input  logic       hostWe,
  output strobesT    st
);
  logic isStore;

  always_comb begin
    st = '0;
    st.src = uopSrc;
    st.dir = uopDir;
    isStore = 1'b0;
    if (uopValid) begin
      case (uopOp)
        OP_ADD:   st.doAdd = 1'b1;
        OP_LDQ:   st.ldQ   = 1'b1;
        OP_LDA:   st.ldA   = 1'b1;
        OP_CLRC:  st.clrC  = 1'b1;
        OP_STSUM: begin isStore = 1'b1; st.storeSum = 1'b1; end
        OP_STMUX: isStore = 1'b1;
        default:  ;
      endcase
    end
    st.memWe = isStore && !hostWe;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.doAdd, st.ldQ, st.ldA, st.clrC, st.memWe})); // R10
endmodule

// File: rtl/bspe_cell.sv
module bspe_cell
  import bspe_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobesT       st,
  input  logic [3:0]    nbrC,
  input  logic          bcast,
  input  logic [AW-1:0] uopAddr,
  input  logic          hostWe,
  input  logic [AW-1:0] hostAddr,
  input  logic          hostBit,
  output logic          qQ,
  output logic          cQ,
  output logic          aQ,
  output logic          rdBit
);
  logic mem [DEPTH];
  logic memBit, muxBit, sumBit, coutBit;

  assign memBit = mem[uopAddr];
  assign rdBit  = mem[hostAddr];

  always_comb begin
    case (st.src)
      SRC_MEM: muxBit = memBit;
      SRC_Q:   muxBit = qQ;
      SRC_A:   muxBit = aQ;
      SRC_NBR: muxBit = nbrC[st.dir];
      SRC_BC:  muxBit = bcast;
      default: muxBit = 1'b0;
    endcase
  end

  assign sumBit  = qQ ^ cQ ^ muxBit;
  assign coutBit = (qQ & cQ) | (qQ & muxBit) | (cQ & muxBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qQ <= 1'b0;
      cQ <= 1'b0;
      aQ <= 1'b1;
    end else begin
      if (st.doAdd) begin
        qQ <= sumBit;
        cQ <= coutBit;
      end
      if (st.ldQ)  qQ <= muxBit;
      if (st.ldA)  aQ <= muxBit;
      if (st.clrC) cQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (hostWe) mem[hostAddr] <= hostBit;
    else if (st.memWe && aQ) mem[uopAddr] <= st.storeSum ? sumBit : muxBit;
  end

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    st.doAdd |=> {cQ, qQ} == $past({1'b0, qQ} + {1'b0, cQ} + {1'b0, muxBit})); // R2
  AST_LOADA: assert property (@(posedge clk) disable iff (!rstN)
    st.ldA |=> aQ == $past(muxBit)); // R3
  AST_CLEAR_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    st.clrC |=> !cQ); // R4
  AST_INACTIVE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (st.memWe && !aQ && !hostWe) |=> (uopAddr != $past(uopAddr)) || (memBit == $past(memBit))); // R7
  AST_HOST_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    hostWe |=> (hostAddr != $past(hostAddr)) || (rdBit == $past(hostBit))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(st.doAdd || st.ldQ || st.ldA || st.clrC) |=> $stable(qQ) && $stable(cQ) && $stable(aQ)); // R10
endmodule

// File: rtl/bspe_datapath.sv
module bspe_datapath
  import bspe_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int NPE = ROWS * COLS
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobesT        st,
  input  logic [AW-1:0]  uopAddr,
  input  logic           bcast,
  input  logic           hostWe,
  input  logic [AW-1:0]  hostAddr,
  input  logic [NPE-1:0] hostWrPlane,
  output logic [NPE-1:0] hostRdPlane,
  output logic [NPE-1:0] qPlane,
  output logic [NPE-1:0] cPlane,
  output logic [NPE-1:0] aPlane
);
  for (genvar r = 0; r < ROWS; r++) begin : gRow
    for (genvar c = 0; c < COLS; c++) begin : gCol
      localparam int P   = r * COLS + c;
      localparam int PN  = ((r + ROWS - 1) % ROWS) * COLS + c;
      localparam int PEA = r * COLS + ((c + 1) % COLS);
      localparam int PS  = ((r + 1) % ROWS) * COLS + c;
      localparam int PW  = r * COLS + ((c + COLS - 1) % COLS);
      logic [3:0] nbr;
      assign nbr = {cPlane[PW], cPlane[PS], cPlane[PEA], cPlane[PN]};

      bspe_cell #(.DEPTH(DEPTH)) i_cell (
        .clk      (clk),
        .rstN     (rstN),
        .st       (st),
        .nbrC     (nbr),
        .bcast    (bcast),
        .uopAddr  (uopAddr),
        .hostWe   (hostWe),
        .hostAddr (hostAddr),
        .hostBit  (hostWrPlane[P]),
        .qQ       (qPlane[P]),
        .cQ       (cPlane[P]),
        .aQ       (aPlane[P]),
        .rdBit    (hostRdPlane[P])
      );
    end
  end
endmodule

// File: rtl/bitplane_grid.sv
module bitplane_grid
  import bspe_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int NPE = ROWS * COLS
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           uopValid,
  input  logic [2:0]     uopOp,
  input  logic [2:0]     uopSrc,
  input  logic [1:0]     uopDir,
  input  logic [AW-1:0]  uopAddr,
  input  logic           uopBcast,
  input  logic           hostWe,
  input  logic [AW-1:0]  hostAddr,
  input  logic [NPE-1:0] hostWrPlane,
  output logic [NPE-1:0] hostRdPlane,
  output logic [NPE-1:0] qPlane,
  output logic [NPE-1:0] cPlane,
  output logic [NPE-1:0] aPlane
);
  strobesT st;

  bspe_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .uopValid (uopValid),
    .uopOp    (uopOp),
    .uopSrc   (uopSrc),
    .uopDir   (uopDir),
    .hostWe   (hostWe),
    .st       (st)
  );

  bspe_datapath #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .uopAddr     (uopAddr),
    .bcast       (uopBcast),
    .hostWe      (hostWe),
    .hostAddr    (hostAddr),
    .hostWrPlane (hostWrPlane),
    .hostRdPlane (hostRdPlane),
    .qPlane      (qPlane),
    .cPlane      (cPlane),
    .aPlane      (aPlane)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (qPlane == '0) && (cPlane == '0) && (aPlane == '1)); // R1
endmodule

// File: tb/test_bitplane_grid.sv
module test_bitplane_grid;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DEPTH = 256;
  localparam int NPE = ROWS * COLS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uopValid = 1'b0;
  logic [2:0] uopOp = '0;
  logic [2:0] uopSrc = '0;
  logic [1:0] uopDir = '0;
  logic [7:0] uopAddr = '0;
  logic uopBcast = 1'b0;
  logic hostWe = 1'b0;
  logic [7:0] hostAddr = '0;
  logic [NPE-1:0] hostWrPlane = '0;
  logic [NPE-1:0] hostRdPlane, qPlane, cPlane, aPlane;

  int total = 0;
  int fails = 0;

  bit mQ [NPE];
  bit mC [NPE];
  bit mA [NPE];
  bit mMem [NPE][DEPTH];

  always #(CLK_PERIOD / 2) clk = ~clk;

  bitplane_grid #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) i_bitplane_grid (
    .clk(clk), .rstN(rstN), .uopValid(uopValid), .uopOp(uopOp), .uopSrc(uopSrc),
    .uopDir(uopDir), .uopAddr(uopAddr), .uopBcast(uopBcast), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWrPlane(hostWrPlane), .hostRdPlane(hostRdPlane),
    .qPlane(qPlane), .cPlane(cPlane), .aPlane(aPlane)
  );

  function automatic int nbrIdx(input int p, input int dir);
    int r = p / COLS;
    int c = p % COLS;
    case (dir)
      0: r = (r + ROWS - 1) % ROWS;
      1: c = (c + 1) % COLS;
      2: r = (r + 1) % ROWS;
      default: c = (c + COLS - 1) % COLS;
    endcase
    return r * COLS + c;
  endfunction

  function automatic logic [NPE-1:0] plane(input int which, input int addr);
    logic [NPE-1:0] v;
    for (int p = 0; p < NPE; p++)
      v[p] = (which == 0) ? mQ[p] : (which == 1) ? mC[p] : (which == 2) ? mA[p] : mMem[p][addr];
    return v;
  endfunction

  task automatic check(input string req, input logic [NPE-1:0] got, input logic [NPE-1:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic checkRegs(input string req);
    check({req, " acc"}, qPlane, plane(0, 0));
    check({req, " carry"}, cPlane, plane(1, 0));
    check({req, " act"}, aPlane, plane(2, 0));
  endtask

  task automatic checkMem(input string req, input int addr);
    hostAddr = addr[7:0];
    #1;
    check({req, " mem"}, hostRdPlane, plane(3, addr));
  endtask

  // One cycle: drive at negedge, update model, return at next negedge.
  task automatic cycle(input bit v, input int op, input int src, input int dir, input int addr,
                       input bit bc, input bit hw, input int ha, input logic [NPE-1:0] hp);
    bit nQ [NPE];
    bit nC [NPE];
    bit nA [NPE];
    uopValid = v; uopOp = op[2:0]; uopSrc = src[2:0]; uopDir = dir[1:0];
    uopAddr = addr[7:0]; uopBcast = bc; hostWe = hw; hostAddr = ha[7:0]; hostWrPlane = hp;
    for (int p = 0; p < NPE; p++) begin
      bit m, s, co;
      case (src)
        0: m = mMem[p][addr];
        1: m = mQ[p];
        2: m = mA[p];
        3: m = mC[nbrIdx(p, dir)];
        4: m = bc;
        default: m = 1'b0;
      endcase
      s = mQ[p] ^ mC[p] ^ m;
      co = (int'(mQ[p]) + int'(mC[p]) + int'(m)) >= 2;
      nQ[p] = mQ[p]; nC[p] = mC[p]; nA[p] = mA[p];
      if (v) begin
        case (op)
          1: begin nQ[p] = s; nC[p] = co; end
          2: nQ[p] = m;
          3: nA[p] = m;
          4: nC[p] = 1'b0;
          5: if (!hw && mA[p]) mMem[p][addr] = s;
          6: if (!hw && mA[p]) mMem[p][addr] = m;
          default: ;
        endcase
      end
      if (hw) mMem[p][ha] = hp[p];
    end
    for (int p = 0; p < NPE; p++) begin
      mQ[p] = nQ[p]; mC[p] = nC[p]; mA[p] = nA[p];
    end
    @(negedge clk);
    uopValid = 1'b0; hostWe = 1'b0;
  endtask

  task automatic hostWrite(input int a, input logic [NPE-1:0] d);
    cycle(0, 0, 0, 0, 0, 0, 1, a, d);
  endtask

  task automatic uop(input int op, input int src, input int dir, input int addr, input bit bc);
    cycle(1, op, src, dir, addr, bc, 0, 0, '0);
  endtask

  task automatic testReset();
    for (int p = 0; p < NPE; p++) begin mQ[p] = 0; mC[p] = 0; mA[p] = 1; end
    checkRegs("R1 reset");
  endtask

  task automatic testPreload();
    hostWrite(10, 16'hA5C3);
    hostWrite(11, 16'h0F0F);
    hostWrite(20, 16'h0000);
    hostWrite(21, 16'hFFFF);
    hostWrite(30, 16'h1234);
    hostWrite(31, 16'h5555);
    checkMem("R8 preload a10", 10);
    checkMem("R8 preload a11", 11);
    checkMem("R8 preload a31", 31);
  endtask

  task automatic testLoads();
    uop(2, 0, 0, 10, 0);
    checkRegs("R3 R5 ldq from mem");
    uop(3, 4, 0, 0, 0);
    checkRegs("R3 R5 lda from bcast 0");
    uop(3, 4, 0, 0, 1);
    checkRegs("R3 lda from bcast 1");
    uop(3, 1, 0, 0, 0);
    checkRegs("R5 lda from acc");
    uop(2, 2, 0, 0, 0);
    checkRegs("R5 ldq from act");
    uop(2, 5, 0, 0, 1);
    checkRegs("R5 src code 5 gives zero");
    uop(3, 4, 0, 0, 1);
  endtask

  task automatic testAdd();
    uop(2, 0, 0, 10, 0);
    uop(4, 0, 0, 0, 0);
    uop(1, 0, 0, 11, 0);
    checkRegs("R2 add mem");
    uop(1, 4, 0, 0, 1);
    checkRegs("R2 add bcast with carry");
    uop(1, 1, 0, 0, 0);
    checkRegs("R2 add acc");
    uop(4, 0, 0, 0, 0);
    checkRegs("R4 clear carry");
  endtask

  task automatic testNeighbours();
    uop(4, 0, 0, 0, 0);
    uop(2, 0, 0, 10, 0);
    uop(1, 4, 0, 0, 1);
    checkRegs("R6 carry pattern setup");
    for (int d = 0; d < 4; d++) begin
      uop(2, 3, d, 0, 0);
      checkRegs($sformatf("R6 R5 neighbour dir %0d", d));
    end
    uop(1, 3, 3, 0, 0);
    checkRegs("R6 ripple add from west");
  endtask

  task automatic testGating();
    uop(3, 0, 0, 11, 0);
    checkRegs("R7 activity from mem");
    uop(6, 4, 0, 20, 1);
    checkRegs("R7 store keeps regs");
    checkMem("R7 stmux gated", 20);
    uop(5, 0, 0, 21, 0);
    checkMem("R7 stsum gated", 21);
    uop(3, 4, 0, 0, 1);
  endtask

  task automatic testSameCycle();
    cycle(1, 6, 4, 0, 31, 0, 1, 30, 16'hBEEF);
    checkMem("R9 store dropped", 31);
    checkMem("R9 host landed", 30);
    cycle(1, 6, 4, 0, 30, 0, 1, 30, 16'hCAFE);
    checkMem("R9 same address host wins", 30);
    cycle(1, 2, 0, 0, 10, 0, 1, 21, 16'h0001);
    checkRegs("R9 ldq with host write");
    checkMem("R9 host write beside ldq", 21);
  endtask

  task automatic testIdle();
    cycle(0, 1, 4, 0, 0, 1, 0, 0, '0);
    checkRegs("R10 valid low add");
    cycle(0, 6, 4, 0, 20, 1, 0, 0, '0);
    checkMem("R10 valid low store", 20);
    uop(7, 4, 0, 20, 1);
    checkRegs("R10 code 7");
    uop(0, 4, 0, 20, 1);
    checkRegs("R10 code 0");
    checkMem("R10 code 0 mem", 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPreload();
    testLoads();
    testAdd();
    testNeighbours();
    testGating();
    testSameCycle();
    testIdle();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule